// File: doc/BRIEF.md
# DMA Channel Major-Loop Controller

This block holds the control and status for the outer, or major, iteration loop of one DMA channel. A loaded beginning count seeds a current iteration counter. Each finished minor loop lowers that counter by one. When the counter reaches zero the block marks the channel done, raises the interrupt requests that are enabled, can drop the channel's hardware request enable, can ask another channel to start, and can ask for a new descriptor to be fetched. The data movers and the descriptor read itself sit outside the block. The block only presents the fetch address and a one-cycle fetch request.

Software drives the block through a four-entry write port. The channel engine drives it through three strobes: service begin, minor loop complete, and error. A three-state machine sequences the work. In `ST_IDLE` the channel waits for service. It moves to `ST_ACTIVE` on `svc_begin`. `ST_ACTIVE` returns to `ST_IDLE` on an error, or on a minor-loop end that leaves the count nonzero. A minor-loop end that takes the count from one to zero moves it instead to `ST_WRAP`. `ST_WRAP` lasts one cycle, produces the completion pulses, and always returns to `ST_IDLE`.

Top module: `dma_major_loop_ctrl`

## Requirements
- R1: After reset, active, done, start, request enable, all three interrupt flags, both request pulses and the current count are all 0.
- R2: Writing select 0 with bit 0 set raises `start_flag`. When `svc_begin` arrives in the idle state, the next cycle shows `active`=1, `start_flag`=0 and `done`=0. If the same cycle also writes select 0 with bit 0 set, that write wins and `start_flag` stays 1.
- R3: `active` falls when a minor loop completes or when `err` is reported. If `err` is high in the same cycle as `minor_done`, the count is left unchanged.
- R4: Writing select 1 loads bits [CW-1:0] into both the beginning and the current count. Each error-free `minor_done` while active lowers a nonzero count by exactly one.
- R5: When the count goes from 1 to 0, one completion cycle follows, and `done` reads 1 after it. On that completion the count reloads from the beginning count if scatter/gather is off. If scatter/gather is on, the count stays at 0.
- R6: A select-0 write made while `done`=1 stores 0 into the link enable (bit 5) and into the scatter/gather enable (bit 4), whatever the data says.
- R7: In the completion cycle with link enable set, `link_req` pulses for one cycle and `link_ch` shows select-0 bits [8+LW-1:8].
- R8: With half enable set (select 0 bit 2), `half_irq` sets when a decrement makes the new count equal to the beginning count shifted right by one.
- R9: With completion interrupt enable set (select 0 bit 1), `end_irq` sets at major-loop completion.
- R10: With disable-request set (select 0 bit 3), `req_en` (written from select 0 bit 7) is cleared at completion. With it clear, `req_en` is left unchanged.
- R11: With scatter/gather enabled at completion and pointer bits [4:0] zero, `sg_fetch_req` pulses with `sg_fetch_addr` equal to the pointer written via select 2. If those pointer bits are nonzero, no request is made and `sg_err` sets.
- R12: Writing select 3 clears `half_irq`, `end_irq` and `sg_err` where data bits 0, 1 and 2 are one. A new set event in the same cycle wins over the clear.
- R13: A select-0 write with bit 6 set clears `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 count, 2 descriptor pointer, 3 interrupt clear |
| wr_data | input | DW | Write data |
| svc_begin | input | 1 | Channel service begins |
| minor_done | input | 1 | Minor loop finished |
| err | input | 1 | Error reported during service |
| start_flag | output | 1 | Software service request pending |
| active | output | 1 | Channel executing a minor loop |
| done | output | 1 | Major loop complete |
| cur_count | output | CW | Current major iteration count |
| req_en | output | 1 | Channel hardware request enable |
| half_irq | output | 1 | Sticky half-point interrupt flag |
| end_irq | output | 1 | Sticky completion interrupt flag |
| sg_err | output | 1 | Sticky misaligned descriptor pointer flag |
| link_req | output | 1 | One-cycle request to start the linked channel |
| link_ch | output | LW | Linked channel number |
| sg_fetch_req | output | 1 | One-cycle descriptor fetch request |
| sg_fetch_addr | output | DW | Descriptor fetch address |

## Verification
The hardest case to reach is the guard that forces the enables to zero. It only shows when a control write lands while `done` is still set from an earlier completion. Its effect only appears one full major loop later, as a missing link pulse and a count that reloads. The stimulus first drives a whole loop to completion. It then writes link and scatter/gather enables on top of the standing `done`, and runs the loop again while it counts link and fetch pulses. Reaching a misaligned fetch takes two steps: a separate write must clear `done` before scatter/gather can be enabled at all. The stimulus also pulses `err` together with `minor_done` so that the count is held and not lowered.

// File: rtl/dml_pkg.sv
package dml_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_WRAP   = 2'd2
    } dml_state_e;

    // register selects
    localparam logic [1:0] SEL_CTRL   = 2'd0;
    localparam logic [1:0] SEL_COUNT  = 2'd1;
    localparam logic [1:0] SEL_SGPTR  = 2'd2;
    localparam logic [1:0] SEL_IRQCLR = 2'd3;

    // control word bit positions
    localparam int B_GO       = 0;
    localparam int B_END_EN   = 1;
    localparam int B_HALF_EN  = 2;
    localparam int B_DREQ     = 3;
    localparam int B_SG_EN    = 4;
    localparam int B_LINK_EN  = 5;
    localparam int B_DONE_CLR = 6;
    localparam int B_REQ_EN   = 7;
    localparam int B_LINKCH   = 8;

    // sticky flag indices in the clear word
    localparam int F_HALF  = 0;
    localparam int F_END   = 1;
    localparam int F_SGERR = 2;
    localparam int N_FLAGS = 3;

    localparam int SG_ALIGN_BITS = 5;

endpackage

// File: rtl/dml_fsm.sv
module dml_fsm
    import dml_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic svc_begin,
    input  logic minor_done,
    input  logic err,
    input  logic cnt_last,
    output logic active,
    output logic wrap,
    output logic accept
);

    dml_state_e state_q;
    dml_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (svc_begin) begin
                    state_d = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (err) begin
                    state_d = ST_IDLE;
                end else if (minor_done && cnt_last) begin
                    state_d = ST_WRAP;
                end else if (minor_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_WRAP: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        active = (state_q == ST_ACTIVE);
        wrap   = (state_q == ST_WRAP);
        accept = (state_q == ST_IDLE) && svc_begin;
    end

    // R3
    err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && err) |=> (state_q == ST_IDLE));

    // R5
    wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRAP) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/dml_iter_cnt.sv
module dml_iter_cnt #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          reload,
    input  logic          dec,
    output logic [CW-1:0] cur,
    output logic          cnt_last,
    output logic          cnt_zero,
    output logic          half_hit
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cur_q;
    logic [CW-1:0] beg_q;
    logic [CW-1:0] cur_dec;

    assign cur_dec  = cur_q - ONE;
    assign cur      = cur_q;
    assign cnt_last = (cur_q == ONE);
    assign cnt_zero = (cur_q == '0);
    assign half_hit = dec && (cur_dec == (beg_q >> 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            beg_q <= '0;
        end else if (load) begin
            cur_q <= load_val;
            beg_q <= load_val;
        end else if (reload) begin
            cur_q <= beg_q;
        end else if (dec) begin
            cur_q <= cur_dec;
        end
    end

    // R4
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !reload) |=> (cur_q == CW'($past(cur_q) - ONE)));

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !load) |=> (cur_q == $past(beg_q)));

endmodule

// File: rtl/dma_major_loop_ctrl.sv
module dma_major_loop_ctrl
    import dml_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 12,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          svc_begin,
    input  logic          minor_done,
    input  logic          err,
    output logic          start_flag,
    output logic          active,
    output logic          done,
    output logic [CW-1:0] cur_count,
    output logic          req_en,
    output logic          half_irq,
    output logic          end_irq,
    output logic          sg_err,
    output logic          link_req,
    output logic [LW-1:0] link_ch,
    output logic          sg_fetch_req,
    output logic [DW-1:0] sg_fetch_addr
);

    logic wr_ctrl, wr_count, wr_sgptr, wr_irqclr;
    logic wrap, accept, cnt_last, cnt_zero, half_hit, dec, reload;
    logic start_q, done_q, end_en_q, half_en_q, dreq_q, sg_en_q, link_en_q, req_en_q;
    logic [LW-1:0] link_ch_q;
    logic [DW-1:0] sg_ptr_q;
    logic sg_aligned;
    logic [N_FLAGS-1:0] flag_set;
    logic [N_FLAGS-1:0] flag_q;

    assign wr_ctrl   = wr_en && (wr_sel == SEL_CTRL);
    assign wr_count  = wr_en && (wr_sel == SEL_COUNT);
    assign wr_sgptr  = wr_en && (wr_sel == SEL_SGPTR);
    assign wr_irqclr = wr_en && (wr_sel == SEL_IRQCLR);

    dml_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .svc_begin  (svc_begin),
        .minor_done (minor_done),
        .err        (err),
        .cnt_last   (cnt_last),
        .active     (active),
        .wrap       (wrap),
        .accept     (accept)
    );

    assign dec    = active && minor_done && !err && !cnt_zero;
    assign reload = wrap && !sg_en_q;

    dml_iter_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_count),
        .load_val (wr_data[CW-1:0]),
        .reload   (reload),
        .dec      (dec),
        .cur      (cur_count),
        .cnt_last (cnt_last),
        .cnt_zero (cnt_zero),
        .half_hit (half_hit)
    );

    // service request and completion flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            if (wr_ctrl && wr_data[B_GO]) begin
                start_q <= 1'b1;
            end else if (accept) begin
                start_q <= 1'b0;
            end
            if (wrap) begin
                done_q <= 1'b1;
            end else if (accept || (wr_ctrl && wr_data[B_DONE_CLR])) begin
                done_q <= 1'b0;
            end
        end
    end

    // control fields; the two chaining enables are guarded by done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_en_q  <= 1'b0;
            half_en_q <= 1'b0;
            dreq_q    <= 1'b0;
            sg_en_q   <= 1'b0;
            link_en_q <= 1'b0;
            req_en_q  <= 1'b0;
            link_ch_q <= '0;
            sg_ptr_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                end_en_q  <= wr_data[B_END_EN];
                half_en_q <= wr_data[B_HALF_EN];
                dreq_q    <= wr_data[B_DREQ];
                sg_en_q   <= wr_data[B_SG_EN] && !done_q;
                link_en_q <= wr_data[B_LINK_EN] && !done_q;
                link_ch_q <= wr_data[B_LINKCH +: LW];
            end
            if (wrap && dreq_q) begin
                req_en_q <= 1'b0;
            end else if (wr_ctrl) begin
                req_en_q <= wr_data[B_REQ_EN];
            end
            if (wr_sgptr) begin
                sg_ptr_q <= wr_data;
            end
        end
    end

    assign sg_aligned = (sg_ptr_q[SG_ALIGN_BITS-1:0] == '0);

    assign flag_set[F_HALF]  = half_hit && half_en_q;
    assign flag_set[F_END]   = wrap && end_en_q;
    assign flag_set[F_SGERR] = wrap && sg_en_q && !sg_aligned;

    for (genvar gi = 0; gi < N_FLAGS; gi++) begin : g_sticky
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (flag_set[gi]) begin
                bit_q <= 1'b1;
            end else if (wr_irqclr && wr_data[gi]) begin
                bit_q <= 1'b0;
            end
        end
        assign flag_q[gi] = bit_q;
    end

    assign start_flag    = start_q;
    assign done          = done_q;
    assign req_en        = req_en_q;
    assign half_irq      = flag_q[F_HALF];
    assign end_irq       = flag_q[F_END];
    assign sg_err        = flag_q[F_SGERR];
    assign link_req      = wrap && link_en_q;
    assign link_ch       = link_ch_q;
    assign sg_fetch_req  = wrap && sg_en_q && sg_aligned;
    assign sg_fetch_addr = sg_ptr_q;

    // R6
    enable_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && done_q) |=> (!sg_en_q && !link_en_q));

    // R10
    dreq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && dreq_q) |=> !req_en);

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(wr_ctrl && wr_data[B_GO])) |=> !start_flag);

    // R11
    misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && sg_en_q && !sg_aligned) |=> sg_err);

    // R5
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> done);

endmodule

// File: tb/dma_major_loop_ctrl_tb_top.sv
module dma_major_loop_ctrl_tb_top;

    localparam int DW = 32;
    localparam int CW = 12;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic          svc_begin = 1'b0;
    logic          minor_done = 1'b0;
    logic          err = 1'b0;
    logic          start_flag, active, done, req_en;
    logic          half_irq, end_irq, sg_err, link_req, sg_fetch_req;
    logic [CW-1:0] cur_count;
    logic [LW-1:0] link_ch;
    logic [DW-1:0] sg_fetch_addr;

    int checks = 0;
    int fails = 0;
    int lr_cnt = 0;
    int fr_cnt = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dma_major_loop_ctrl #(.DW(DW), .CW(CW), .LW(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .svc_begin(svc_begin), .minor_done(minor_done), .err(err),
        .start_flag(start_flag), .active(active), .done(done), .cur_count(cur_count),
        .req_en(req_en), .half_irq(half_irq), .end_irq(end_irq), .sg_err(sg_err),
        .link_req(link_req), .link_ch(link_ch), .sg_fetch_req(sg_fetch_req),
        .sg_fetch_addr(sg_fetch_addr)
    );

    // behavioural reference model
    int            m_phase;   // 0 waiting, 1 serving, 2 completing
    logic [CW-1:0] m_cur, m_beg;
    bit m_start, m_done, m_end_en, m_half_en, m_dreq, m_sg_en, m_link_en, m_req_en;
    bit m_half, m_end, m_sgerr;
    logic [LW-1:0] m_ch;
    logic [DW-1:0] m_ptr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cur = '0; m_beg = '0;
            m_start = 0; m_done = 0; m_end_en = 0; m_half_en = 0; m_dreq = 0;
            m_sg_en = 0; m_link_en = 0; m_req_en = 0;
            m_half = 0; m_end = 0; m_sgerr = 0; m_ch = '0; m_ptr = '0;
        end else begin
            int n_phase;
            bit took, stepped, completing, old_done, old_dreq, old_sg, old_half_en, old_end_en;
            bit wc;
            logic [CW-1:0] n_cur;
            took = (m_phase == 0) && svc_begin;
            completing = (m_phase == 2);
            stepped = (m_phase == 1) && minor_done && !err && (m_cur != 0);
            old_done = m_done; old_dreq = m_dreq; old_sg = m_sg_en;
            old_half_en = m_half_en; old_end_en = m_end_en;
            wc = wr_en && (wr_sel == 2'd0);
            n_phase = m_phase;
            if (m_phase == 0 && svc_begin) n_phase = 1;
            else if (m_phase == 1 && err) n_phase = 0;
            else if (m_phase == 1 && minor_done) n_phase = (m_cur == 1) ? 2 : 0;
            else if (m_phase == 2) n_phase = 0;
            n_cur = m_cur;
            if (wr_en && wr_sel == 2'd1) begin
                n_cur = wr_data[CW-1:0];
                m_beg = wr_data[CW-1:0];
            end else if (completing && !old_sg) n_cur = m_beg;
            else if (stepped) n_cur = m_cur - 1'b1;
            if (wr_en && wr_sel == 2'd3) begin
                if (wr_data[0]) m_half = 0;
                if (wr_data[1]) m_end = 0;
                if (wr_data[2]) m_sgerr = 0;
            end
            if (stepped && old_half_en && ((m_cur - 1'b1) == (m_beg >> 1))) m_half = 1;
            if (completing && old_end_en) m_end = 1;
            if (completing && old_sg && (m_ptr[4:0] != 0)) m_sgerr = 1;
            if (took) m_start = 0;
            if (wc && wr_data[0]) m_start = 1;
            if (took || (wc && wr_data[6])) m_done = 0;
            if (completing) m_done = 1;
            if (wc) begin
                m_end_en = wr_data[1]; m_half_en = wr_data[2]; m_dreq = wr_data[3];
                m_sg_en = wr_data[4] && !old_done; m_link_en = wr_data[5] && !old_done;
                m_req_en = wr_data[7]; m_ch = wr_data[8 +: LW];
            end
            if (completing && old_dreq) m_req_en = 0;
            if (wr_en && wr_sel == 2'd2) m_ptr = wr_data;
            m_cur = n_cur;
            m_phase = n_phase;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic cmp(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            cmp("R2 start_flag", int'(start_flag), int'(m_start));
            cmp("R3 active", int'(active), int'(m_phase == 1));
            cmp("R5 done", int'(done), int'(m_done));
            cmp("R4 cur_count", int'(cur_count), int'(m_cur));
            cmp("R10 req_en", int'(req_en), int'(m_req_en));
            cmp("R8 half_irq", int'(half_irq), int'(m_half));
            cmp("R9 end_irq", int'(end_irq), int'(m_end));
            cmp("R11 sg_err", int'(sg_err), int'(m_sgerr));
            cmp("R7 link_req", int'(link_req), int'(m_phase == 2 && m_link_en));
            cmp("R7 link_ch", int'(link_ch), int'(m_ch));
            cmp("R11 sg_fetch_req", int'(sg_fetch_req),
                int'(m_phase == 2 && m_sg_en && m_ptr[4:0] == 0));
            cmp("R11 sg_fetch_addr", int'(sg_fetch_addr), int'(m_ptr));
            if (link_req) lr_cnt++;
            if (sg_fetch_req) fr_cnt++;
        end
    end

    task automatic wr(input logic [1:0] s, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic loop1();
        @(negedge clk);
        svc_begin = 1'b1;
        @(negedge clk);
        svc_begin = 1'b0;
        cmp("R2 active after service begin", int'(active), 1);
        minor_done = 1'b1;
        @(negedge clk);
        minor_done = 1'b0;
    endtask

    task automatic errloop(input bit with_minor);
        @(negedge clk);
        svc_begin = 1'b1;
        @(negedge clk);
        svc_begin = 1'b0;
        err = 1'b1;
        minor_done = with_minor;
        @(negedge clk);
        err = 1'b0;
        minor_done = 1'b0;
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog expired act=0 exp=1");
            summary();
            $finish;
        end
    end

    initial begin
        int lr0, fr0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        cmp("R1 active", int'(active), 0);
        cmp("R1 done", int'(done), 0);
        cmp("R1 start", int'(start_flag), 0);
        cmp("R1 count", int'(cur_count), 0);
        cmp("R1 irq flags", int'({half_irq, end_irq, sg_err}), 0);
        cmp("R1 pulses", int'({link_req, sg_fetch_req}), 0);
        cmp("R1 req_en", int'(req_en), 0);

        // full loop with link, half, end, disable-request
        wr(2'd1, 32'd4);
        cmp("R4 count load", int'(cur_count), 4);
        wr(2'd0, 32'h5AF);
        cmp("R2 start set", int'(start_flag), 1);
        cmp("R10 req_en set", int'(req_en), 1);
        loop1();
        cmp("R2 start cleared", int'(start_flag), 0);
        cmp("R4 first step", int'(cur_count), 3);
        cmp("R3 active falls", int'(active), 0);
        cmp("R8 no early half", int'(half_irq), 0);
        loop1();
        cmp("R8 half point", int'(half_irq), 1);
        loop1();
        loop1();
        cmp("R7 link pulse", int'(link_req), 1);
        cmp("R7 link channel", int'(link_ch), 5);
        @(negedge clk);
        cmp("R5 done set", int'(done), 1);
        cmp("R9 end flag", int'(end_irq), 1);
        cmp("R10 req_en cleared", int'(req_en), 0);
        cmp("R5 reload", int'(cur_count), 4);

        // enables written while done must not take effect
        wr(2'd0, 32'h32);
        lr0 = lr_cnt; fr0 = fr_cnt;
        loop1();
        cmp("R2 done cleared by service", int'(done), 0);
        loop1(); loop1(); loop1();
        @(negedge clk);
        cmp("R6 no link", lr_cnt - lr0, 0);
        cmp("R6 no fetch", fr_cnt - fr0, 0);
        cmp("R6 count reloaded", int'(cur_count), 4);

        // error paths
        errloop(1'b0);
        cmp("R3 error drops active", int'(active), 0);
        cmp("R3 count held", int'(cur_count), 4);
        errloop(1'b1);
        cmp("R3 error with minor", int'(active), 0);
        cmp("R3 count held with minor", int'(cur_count), 4);

        // sticky clear
        wr(2'd3, 32'h3);
        cmp("R12 half cleared", int'(half_irq), 0);
        cmp("R12 end cleared", int'(end_irq), 0);

        // aligned scatter/gather
        wr(2'd2, 32'h100);
        wr(2'd1, 32'd2);
        wr(2'd0, 32'h10);
        loop1();
        loop1();
        cmp("R11 fetch pulse", int'(sg_fetch_req), 1);
        cmp("R11 fetch address", int'(sg_fetch_addr), 32'h100);
        @(negedge clk);
        cmp("R5 count held at zero", int'(cur_count), 0);
        wr(2'd0, 32'h40);
        cmp("R13 done cleared", int'(done), 0);

        // misaligned scatter/gather
        wr(2'd2, 32'h104);
        wr(2'd1, 32'd1);
        wr(2'd0, 32'h10);
        loop1();
        cmp("R11 no misaligned fetch", int'(sg_fetch_req), 0);
        @(negedge clk);
        cmp("R11 sg_err set", int'(sg_err), 1);
        wr(2'd3, 32'h4);
        cmp("R12 sg_err cleared", int'(sg_err), 0);

        // request enable kept without disable-request
        wr(2'd0, 32'h40);
        wr(2'd1, 32'd1);
        wr(2'd0, 32'h80);
        loop1();
        @(negedge clk);
        cmp("R10 req_en kept", int'(req_en), 1);
        cmp("R5 done after single loop", int'(done), 1);

        // start write in the same cycle as service begin
        @(negedge clk);
        svc_begin = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h1;
        @(negedge clk);
        svc_begin = 1'b0; wr_en = 1'b0; wr_data = '0;
        cmp("R2 set wins over clear", int'(start_flag), 1);
        err = 1'b1;
        @(negedge clk);
        err = 1'b0;

        repeat (3) @(negedge clk);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule